// File: doc/BRIEF.md
# Instruction Fetch Stage with Static Branch Prediction

This block keeps an execute stage supplied with instructions. It reads 17-bit instructions from a behavioural single-port instruction RAM of 2^AW words. Each instruction goes into a small queue together with the 10-bit address it came from. The execute stage sees the oldest entry on a valid/ready stream. It takes that entry by holding `head_ready` high in a cycle where `head_valid` is high. While `head_ready` stays low the head entry holds steady, and fetching stops before the queue can overflow.

The next fetch address comes from the returned instruction alone. Bit 5 of each instruction is a static taken hint, and bits 4..0 hold a signed branch offset. When the hint is set, fetch jumps to the instruction's own address plus the sign-extended offset. When the hint is clear, fetch moves on to the next word. Both cases wrap modulo 2^AW. The RAM read takes one cycle. Because the next address is formed in the cycle the word returns, fetch can issue one read per cycle.

The back end can issue a redirect. A redirect empties the queue and resumes fetching at the address it supplies. An external port can also load or store any RAM word. Only one RAM access happens per cycle. The port is granted in this order: external load or store, then reset, then redirect, then ordinary fetch.

Top module: `insn_fetch`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `head_valid` is 0. The first entry delivered after reset comes from address 0.
- R2: For an instruction at address P, the next fetch address is P + sign-extended bits 4..0 when bit 5 is 1, and P + 1 when bit 5 is 0. Both wrap modulo 2^AW, so 1023 is followed by 0.
- R3: Every delivered entry pairs `head_pc` with `head_insn`, where `head_insn` is the RAM word at `head_pc`. Entries arrive in the order that R2 defines.
- R4: An entry is consumed only in a cycle where both `head_valid` and `head_ready` are high. While `head_valid` is high and `head_ready` is low, `head_pc` and `head_insn` stay unchanged into the next cycle.
- R5: The queue never holds more than DEPTH entries. No instruction is lost or repeated, however long back-pressure lasts.
- R6: In a cycle where `redirect` is high, all queued entries are discarded, and a dequeue in that same cycle has no effect. `head_valid` is 0 in the following cycle. The next entry delivered comes from `redirect_pc`.
- R7: Reset outranks redirect. A redirect asserted during reset is ignored, and fetching still starts at address 0.
- R8: A load is signalled by `mem_req`=1 with `mem_write`=0. In the next cycle, `mem_rvalid` is 1 and `mem_rdata` holds the addressed word. In any cycle that does not follow a load, `mem_rvalid` is 0.
- R9: A store is signalled by `mem_req`=1 with `mem_write`=1. It writes `mem_wdata` to `mem_addr`, and later loads and fetches see the new value. Stores also take effect while `rst` is high.
- R10: A cycle with `mem_req` high issues no fetch, and no fetch result returns in the cycle after it. The instruction stream then continues without a gap or a skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| redirect | input | 1 | Flush the queue and restart fetch |
| redirect_pc | input | AW | Address where fetch resumes after a redirect |
| head_valid | output | 1 | Queue head holds an entry |
| head_ready | input | 1 | Execute stage accepts the head entry |
| head_pc | output | AW | Address of the head instruction |
| head_insn | output | IW | Head instruction word |
| mem_req | input | 1 | External RAM access request |
| mem_write | input | 1 | 1 selects a store, 0 selects a load |
| mem_addr | input | AW | External access address |
| mem_wdata | input | IW | Store data |
| mem_rdata | output | IW | Load data |
| mem_rvalid | output | 1 | Load data is valid, one cycle after the load request |

## Verification
The bench keeps IW=17, AW=10 and OW=5. This keeps the full 1024-word address space in play, so wrap-around at 1023 and backward branches below address 0 can both be reached. The bench lowers DEPTH to 4. A few cycles of withheld `head_ready` then fill the queue, and the in-flight reservation is exercised often under random back-pressure. The whole RAM is written during reset, which checks that stores take priority over reset.

// File: rtl/insn_fetch_pkg.sv
package insn_fetch_pkg;
  // Which requester owns the single RAM port in a cycle, highest first.
  typedef enum logic [1:0] {
    OWN_MEM   = 2'd0,
    OWN_RESET = 2'd1,
    OWN_REDIR = 2'd2,
    OWN_FETCH = 2'd3
  } port_owner_e;
endpackage

// File: rtl/insn_fetch_ram.sv
module insn_fetch_ram #(
  parameter int IW = 17,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [IW-1:0] wdata,
  output logic [IW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [IW-1:0] cells [WORDS];

  // Single port: one read or one write per cycle; read data registered.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) cells[addr] <= wdata;
      else    rdata       <= cells[addr];
    end
  end
endmodule

// File: rtl/insn_fetch_nextpc.sv
module insn_fetch_nextpc #(
  parameter int IW = 17,
  parameter int AW = 10,
  parameter int OW = 5
) (
  input  logic [AW-1:0] pc,
  input  logic [IW-1:0] insn,
  output logic [AW-1:0] next_pc
);
  localparam int FLAG_BIT = OW;

  logic [AW-1:0] offset_ext;

  generate
    if (AW > OW) begin : g_sext
      assign offset_ext = {{(AW-OW){insn[OW-1]}}, insn[OW-1:0]};
    end else begin : g_trunc
      assign offset_ext = insn[AW-1:0];
    end
  endgenerate

  always_comb begin
    if (insn[FLAG_BIT]) next_pc = pc + offset_ext;
    else                next_pc = pc + AW'(1);
  end
endmodule

// File: rtl/insn_fetch_queue.sv
module insn_fetch_queue #(
  parameter int W     = 27,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head_data,
  output logic          head_valid,
  output logic [CW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  assign head_data  = slots[rd_ptr];
  assign head_valid = (count != '0);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !rst && !flush) slots[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/insn_fetch.sv
module insn_fetch
  import insn_fetch_pkg::*;
#(
  parameter int IW    = 17,
  parameter int AW    = 10,
  parameter int OW    = 5,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_pc,
  output logic          head_valid,
  input  logic          head_ready,
  output logic [AW-1:0] head_pc,
  output logic [IW-1:0] head_insn,
  input  logic          mem_req,
  input  logic          mem_write,
  input  logic [AW-1:0] mem_addr,
  input  logic [IW-1:0] mem_wdata,
  output logic [IW-1:0] mem_rdata,
  output logic          mem_rvalid
);
  localparam int QW = AW + IW;
  localparam int CW = $clog2(DEPTH + 1);

  port_owner_e   owner;
  logic [AW-1:0] pc_q;          // address of the last issued (or stalled) fetch
  logic          fetch_pend_q;  // a fetch read returns this cycle
  logic          ld_pend_q;
  logic [IW-1:0] ram_rdata;
  logic [AW-1:0] chain_pc;
  logic [AW-1:0] seq_addr;
  logic          enq, deq, issue;
  logic [CW:0]   occ_next;
  logic [CW-1:0] q_count;
  logic [QW-1:0] q_head;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;

  // Port arbitration: external access, reset, redirect, fetch.
  always_comb begin
    if (mem_req)       owner = OWN_MEM;
    else if (rst)      owner = OWN_RESET;
    else if (redirect) owner = OWN_REDIR;
    else               owner = OWN_FETCH;
  end

  insn_fetch_nextpc #(.IW(IW), .AW(AW), .OW(OW)) nextpc_i (
    .pc      (pc_q),
    .insn    (ram_rdata),
    .next_pc (chain_pc)
  );

  assign seq_addr = fetch_pend_q ? chain_pc : pc_q;
  assign enq      = fetch_pend_q && !rst && !redirect;
  assign deq      = head_valid && head_ready && !rst && !redirect;
  assign occ_next = {1'b0, q_count} + {{CW{1'b0}}, enq} - {{CW{1'b0}}, deq};

  always_comb begin
    case (owner)
      OWN_REDIR: issue = 1'b1;
      OWN_FETCH: issue = (occ_next < (CW+1)'(DEPTH));
      default:   issue = 1'b0;
    endcase
  end

  always_comb begin
    ram_en   = mem_req || issue;
    ram_we   = mem_req && mem_write;
    ram_addr = mem_req ? mem_addr : ((owner == OWN_REDIR) ? redirect_pc : seq_addr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q         <= '0;
      fetch_pend_q <= 1'b0;
    end else if (redirect) begin
      pc_q         <= redirect_pc;
      fetch_pend_q <= issue;
    end else begin
      pc_q         <= seq_addr;
      fetch_pend_q <= issue;
    end
  end

  // Load data valid flag follows the port even during reset.
  always_ff @(posedge clk) begin
    ld_pend_q <= mem_req && !mem_write;
  end

  insn_fetch_ram #(.IW(IW), .AW(AW)) ram_i (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (mem_wdata),
    .rdata (ram_rdata)
  );

  insn_fetch_queue #(.W(QW), .DEPTH(DEPTH), .CW(CW)) queue_i (
    .clk        (clk),
    .rst        (rst),
    .flush      (redirect),
    .push       (enq),
    .push_data  ({pc_q, ram_rdata}),
    .pop        (deq),
    .head_data  (q_head),
    .head_valid (head_valid),
    .count      (q_count)
  );

  assign head_pc    = q_head[QW-1:IW];
  assign head_insn  = q_head[IW-1:0];
  assign mem_rdata  = ram_rdata;
  assign mem_rvalid = ld_pend_q;
endmodule

// File: rtl/insn_fetch_chk.sv
module insn_fetch_chk #(
  parameter int IW    = 17,
  parameter int AW    = 10,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          redirect,
  input logic          head_valid,
  input logic          head_ready,
  input logic [AW-1:0] head_pc,
  input logic [IW-1:0] head_insn,
  input logic          mem_req,
  input logic          mem_write,
  input logic          mem_rvalid,
  input logic [CW-1:0] q_count,
  input logic          fetch_pend
);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (head_valid && !head_ready && !redirect) |=>
      (head_valid && $stable(head_pc) && $stable(head_insn)));

  p_flush_r6: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !head_valid);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    q_count <= CW'(DEPTH));

  p_load_resp_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_write) |=> mem_rvalid);

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && !mem_write) |=> !mem_rvalid);

  p_port_taken_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !fetch_pend);
endmodule

bind insn_fetch insn_fetch_chk #(.IW(IW), .AW(AW), .DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .redirect   (redirect),
  .head_valid (head_valid),
  .head_ready (head_ready),
  .head_pc    (head_pc),
  .head_insn  (head_insn),
  .mem_req    (mem_req),
  .mem_write  (mem_write),
  .mem_rvalid (mem_rvalid),
  .q_count    (q_count),
  .fetch_pend (fetch_pend_q)
);

// File: tb/insn_fetch_tb_top.sv
module insn_fetch_tb_top;
  localparam int IW = 17;
  localparam int AW = 10;
  localparam int OW = 5;
  localparam int DEPTH = 4;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          redirect = 1'b0;
  logic [AW-1:0] redirect_pc = '0;
  logic          head_valid;
  logic          head_ready = 1'b0;
  logic [AW-1:0] head_pc;
  logic [IW-1:0] head_insn;
  logic          mem_req = 1'b0;
  logic          mem_write = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [IW-1:0] mem_wdata = '0;
  logic [IW-1:0] mem_rdata;
  logic          mem_rvalid;

  always #5 clk = ~clk;

  insn_fetch #(.IW(IW), .AW(AW), .OW(OW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .redirect(redirect), .redirect_pc(redirect_pc),
    .head_valid(head_valid), .head_ready(head_ready), .head_pc(head_pc),
    .head_insn(head_insn), .mem_req(mem_req), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid)
  );

  logic [IW-1:0] mem_m [WORDS];
  logic [AW-1:0] exp_pc = '0;
  logic          ld_chk = 1'b0;
  logic [IW-1:0] ld_exp = '0;
  int            n_checks = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] model_next(input logic [AW-1:0] pc,
                                               input logic [IW-1:0] w);
    logic [AW-1:0] off;
    off = {{(AW-OW){w[OW-1]}}, w[OW-1:0]};
    return w[OW] ? pc + off : pc + AW'(1);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Monitor: sampled on the falling edge, before the inputs are taken.
  always @(negedge clk) begin
    if (!done) begin
      if (!rst) begin
        if (ld_chk) check(mem_rvalid && mem_rdata == ld_exp, "R8 load data",
                          {14'd0, mem_rvalid, mem_rdata}, {14'd0, 1'b1, ld_exp});
        else        check(!mem_rvalid, "R8 no load pulse", {31'd0, mem_rvalid}, 32'd0);
      end
      ld_chk = mem_req && !mem_write;
      ld_exp = mem_m[mem_addr];
      if (mem_req && mem_write) mem_m[mem_addr] = mem_wdata;
      if (rst) exp_pc = '0;
      else if (redirect) exp_pc = redirect_pc;
      else if (head_valid && head_ready) begin
        check(head_pc == exp_pc, "R3 R2 head address", {22'd0, head_pc}, {22'd0, exp_pc});
        check(head_insn == mem_m[exp_pc], "R3 head word", {15'd0, head_insn},
              {15'd0, mem_m[exp_pc]});
        exp_pc = model_next(exp_pc, mem_m[exp_pc]);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [IW-1:0] w;
    void'($urandom(32'h5eed_1234));
    step();
    // R9 stores during reset fill the RAM; R7 redirects during reset are ignored.
    for (int a = 0; a < WORDS; a++) begin
      w = IW'($urandom);
      w[OW] = ($urandom % 10) < 3;
      mem_req = 1'b1; mem_write = 1'b1; mem_addr = AW'(a); mem_wdata = w;
      redirect = ($urandom % 4) == 0;
      redirect_pc = AW'($urandom);
      step();
    end
    mem_req = 1'b0; mem_write = 1'b0;
    redirect = 1'b1; redirect_pc = AW'(77);
    step();
    @(negedge clk);
    check(!head_valid, "R1 empty in reset", {31'd0, head_valid}, 32'd0);
    @(posedge clk); #1;
    rst = 1'b0; redirect = 1'b0;
    @(negedge clk);
    check(!head_valid, "R1 empty at reset release", {31'd0, head_valid}, 32'd0);
    @(negedge clk);
    check(!head_valid, "R1 empty first cycle after reset", {31'd0, head_valid}, 32'd0);
    @(negedge clk);
    check(head_valid && head_pc == '0, "R1 first entry from 0", {22'd0, head_pc}, 32'd0);
    @(posedge clk); #1;

    // Random traffic: back-pressure, redirects, loads.
    for (int c = 0; c < 4000; c++) begin
      head_ready  = ($urandom % 10) < 7;
      redirect    = ($urandom % 40) == 0;
      redirect_pc = AW'($urandom);
      mem_req     = ($urandom % 10) == 0;
      mem_write   = 1'b0;
      mem_addr    = AW'($urandom);
      step();
    end
    redirect = 1'b0; mem_req = 1'b0;

    // R5: long stall fills the queue, then the stream resumes intact.
    head_ready = 1'b0;
    repeat (30) step();
    @(negedge clk);
    check(head_valid, "R5 queue holds entries under stall", {31'd0, head_valid}, 32'd1);
    @(posedge clk); #1;
    head_ready = 1'b1;
    repeat (40) step();

    // R10: loads every other cycle while draining.
    for (int c = 0; c < 60; c++) begin
      mem_req = c[0]; mem_write = 1'b0; mem_addr = AW'($urandom);
      step();
    end
    mem_req = 1'b0;

    // R2 wrap: 2 -> 1022 (offset -4), 1022 -> 1023 -> 0.
    head_ready = 1'b0;
    mem_req = 1'b1; mem_write = 1'b1;
    mem_addr = AW'(2);    mem_wdata = {11'h2a5, 1'b1, 5'b11100}; step();
    mem_addr = AW'(1022); mem_wdata = {11'h013, 1'b0, 5'b00111}; step();
    mem_addr = AW'(1023); mem_wdata = {11'h3c0, 1'b0, 5'b10101}; step();
    mem_write = 1'b0; mem_addr = AW'(2); step();
    mem_req = 1'b0;
    @(negedge clk);
    check(mem_rvalid && mem_rdata == {11'h2a5, 1'b1, 5'b11100}, "R9 store read back",
          {15'd0, mem_rdata}, {15'd0, 11'h2a5, 1'b1, 5'b11100});
    @(posedge clk); #1;
    // R6: redirect with a dequeue in the same cycle; the dequeue is discarded.
    head_ready = 1'b1; redirect = 1'b1; redirect_pc = AW'(2);
    step();
    redirect = 1'b0;
    @(negedge clk);
    check(!head_valid, "R6 empty after redirect", {31'd0, head_valid}, 32'd0);
    @(posedge clk); #1;
    @(negedge clk);
    check(head_valid && head_pc == AW'(2), "R6 first entry from redirect_pc",
          {22'd0, head_pc}, 32'd2);
    @(negedge clk);
    check(head_valid && head_pc == AW'(1022), "R2 backward branch target",
          {22'd0, head_pc}, 32'd1022);
    @(negedge clk);
    check(head_valid && head_pc == AW'(1023), "R2 sequential step",
          {22'd0, head_pc}, 32'd1023);
    @(negedge clk);
    check(head_valid && head_pc == '0, "R2 wrap to zero", {22'd0, head_pc}, 32'd0);
    @(posedge clk); #1;
    repeat (30) step();
    head_ready = 1'b0;
    step();
    finish_run();
  end
endmodule